// File: doc/BRIEF.md
# Multi-Word Level Interrupt Aggregator

This block collects a set of level-sensitive interrupt sources, arranged as 32-bit words, and produces one parent interrupt line for each CPU. Every CPU owns a separate mask bank. All banks share one synchronized view of the sources. A source reaches a CPU's parent line only while the source is high and that CPU has it unmasked.

Software reaches the block through a plain single-cycle read/write port. The port has a bank select and a byte offset. Each bank has four register groups of `NUM_WORDS` words each, placed one after another: raw source status, mask readback, a mask set port and a mask clear port. The set and clear ports act only on the bits written as 1. No read-modify-write is needed, so one CPU can change a single source without disturbing the other bits.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset every mask bit of every bank is 1, every parent line is 0 and the read data output is 0.
- R2: Offset bits [1:0] are ignored. Byte offset (g*NUM_WORDS + w)*4 selects word w of group g. The group codes are 0 = status, 1 = mask readback, 2 = mask set and 3 = mask clear. Bit b of word w belongs to source 32*w + b.
- R3: A write to the mask set group sets each mask bit whose written bit is 1 and leaves the others unchanged.
- R4: A write to the mask clear group clears each mask bit whose written bit is 1 and leaves the others unchanged.
- R5: A bank's parent line is 1 exactly when at least one source is 1 in status while its mask bit in that bank is 0.
- R6: Each bank has its own mask, and a write to one bank leaves the other banks' masks unchanged. Status reads return the same source view from every bank.
- R7: Writes to the status and mask readback groups are ignored. Reads of the mask set and mask clear groups return 0.
- R8: An access at a byte offset of 16*NUM_WORDS or above, or to a bank index of NUM_CPUS or above, reads 0 and changes no mask.
- R9: Each source passes through two flip-flops before it reaches status. A source change applied before clock edge k is visible in status and on the parent line after edge k+1.
- R10: Read data is registered on the clock edge that samples a read (enable high, write low). It holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32*NUM_WORDS | Level interrupt sources; bit 32*w+b is source b of word w |
| bus_en_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_bank_i | input | BANK_W | CPU bank index |
| bus_addr_i | input | ADDR_W | Byte offset inside the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CPUS | Parent interrupt line per CPU bank |

## Verification
The bound checker watches bank 0 on every cycle. It checks that set and clear writes to word 0 land the written ones, and that writes to read-only or out-of-range offsets leave every mask unchanged. It also checks that read data holds between reads, that a parent line is never high while status is all zero, and that reset leaves all masks set. Other behaviour shows only in the bench scenarios. These cover the packed offset map for the configured word count, independence between banks, zero readback of the write-only ports, and the two-edge delay from a source to its parent line. They also cover dropping the parent line by masking, and a reset in the middle of a run.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int unsigned BITS_PER_WORD = 32;
    localparam int unsigned WORD_LIMIT    = 8;
    localparam int unsigned GROUP_COUNT   = 4;
    localparam int unsigned BYTES_PER_REG = 4;

    typedef logic [BITS_PER_WORD-1:0] word_t;

    // Group order is part of the address map: status, mask view, set, clear
    typedef enum logic [1:0] {
        GRP_RAW    = 2'd0,
        GRP_MASKRD = 2'd1,
        GRP_MSET   = 2'd2,
        GRP_MCLR   = 2'd3
    } grp_e;

    typedef struct packed {
        logic       hit;
        grp_e       grp;
        logic [2:0] word;
    } dec_t;

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/lvl_irq_decode.sv
module lvl_irq_decode
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int unsigned IDX_W   = ADDR_W - 2;
    localparam int unsigned REG_CNT = GROUP_COUNT * NUM_WORDS;

    logic [IDX_W-1:0] idx;
    logic [31:0]      idx_ext;

    assign idx     = addr_i[ADDR_W-1:2];
    assign idx_ext = 32'(idx);

    always_comb begin
        dec_o.hit  = (idx_ext < REG_CNT);
        dec_o.grp  = GRP_RAW;
        dec_o.word = '0;
        if (dec_o.hit) begin
            dec_o.grp  = grp_e'(2'(idx_ext / NUM_WORDS));
            dec_o.word = 3'(idx_ext % NUM_WORDS);
        end
    end
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_i,
    input  grp_e                                 grp_i,
    input  logic [2:0]                           word_i,
    input  word_t                                wdata_i,
    input  logic [NUM_WORDS*BITS_PER_WORD-1:0]   status_i,
    output logic [NUM_WORDS*BITS_PER_WORD-1:0]   mask_o,
    output logic                                 irq_o
);
    localparam int unsigned VEC_W = NUM_WORDS * BITS_PER_WORD;

    logic [VEC_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (wr_i) begin
            for (int w = 0; w < int'(NUM_WORDS); w++) begin
                if (word_i == 3'(w)) begin
                    unique case (grp_i)
                        GRP_MSET: mask_q[w*BITS_PER_WORD +: BITS_PER_WORD] <=
                                  mask_q[w*BITS_PER_WORD +: BITS_PER_WORD] | wdata_i;
                        GRP_MCLR: mask_q[w*BITS_PER_WORD +: BITS_PER_WORD] <=
                                  mask_q[w*BITS_PER_WORD +: BITS_PER_WORD] & ~wdata_i;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = |(status_i & ~mask_q);
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned NUM_CPUS  = 2,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned BANK_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int unsigned SRC_W    = NUM_WORDS * BITS_PER_WORD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_W-1:0]    src_i,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic [BANK_W-1:0]   bus_bank_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_CPUS-1:0] irq_o
);
    logic [SRC_W-1:0]          status_q;
    logic [NUM_CPUS*SRC_W-1:0] mask_all;
    dec_t                      dec;
    logic                      bank_ok;
    word_t                     stat_word;
    word_t                     mask_word;
    word_t                     rd_next;
    word_t                     rdata_q;

    lvl_irq_sync #(.WIDTH(SRC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (status_q)
    );

    lvl_irq_decode #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    assign bank_ok = (32'(bus_bank_i) < NUM_CPUS);

    for (genvar c = 0; c < int'(NUM_CPUS); c++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_en_i && bus_we_i && dec.hit && (32'(bus_bank_i) == c);

        lvl_irq_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_i     (bank_wr),
            .grp_i    (dec.grp),
            .word_i   (dec.word),
            .wdata_i  (bus_wdata_i),
            .status_i (status_q),
            .mask_o   (mask_all[c*SRC_W +: SRC_W]),
            .irq_o    (irq_o[c])
        );
    end

    always_comb begin
        stat_word = '0;
        mask_word = '0;
        for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (dec.word == 3'(w)) begin
                stat_word = status_q[w*BITS_PER_WORD +: BITS_PER_WORD];
                for (int c = 0; c < int'(NUM_CPUS); c++) begin
                    if (32'(bus_bank_i) == c) begin
                        mask_word = mask_all[c*SRC_W + w*BITS_PER_WORD +: BITS_PER_WORD];
                    end
                end
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (dec.hit && bank_ok) begin
            unique case (dec.grp)
                GRP_RAW:    rd_next = stat_word;
                GRP_MASKRD: rd_next = mask_word;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_en_i && !bus_we_i) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/lvl_irq_agg_chk.sv
module lvl_irq_agg_chk #(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned NUM_CPUS  = 2,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BANK_W    = 1,
    parameter int unsigned SRC_W     = 128
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_en_i,
    input logic                      bus_we_i,
    input logic [BANK_W-1:0]         bus_bank_i,
    input logic [ADDR_W-1:0]         bus_addr_i,
    input logic [31:0]               bus_wdata_i,
    input logic [31:0]               bus_rdata_o,
    input logic [NUM_CPUS-1:0]       irq_o,
    input logic [SRC_W-1:0]          status_w,
    input logic [NUM_CPUS*SRC_W-1:0] masks_w
);
    localparam logic [ADDR_W-1:0] A_STAT0 = '0;
    localparam logic [ADDR_W-1:0] A_MRD0  = ADDR_W'(4 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] A_MSET0 = ADDR_W'(8 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] A_MCLR0 = ADDR_W'(12 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(16 * NUM_WORDS);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            // R1
            reset_state_chk: assert (masks_w == '1 && irq_o == '0 && bus_rdata_o == '0);
        end
    end

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en_i && bus_we_i && bus_bank_i == '0 && bus_addr_i == A_MSET0)
        |=> ((masks_w[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en_i && bus_we_i && bus_bank_i == '0 && bus_addr_i == A_MCLR0)
        |=> ((masks_w[31:0] & $past(bus_wdata_i)) == 32'h0));

    // R7
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en_i && bus_we_i && (bus_addr_i == A_STAT0 || bus_addr_i == A_MRD0))
        |=> $stable(masks_w));

    // R8
    oor_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en_i && bus_we_i && bus_addr_i >= A_END)
        |=> $stable(masks_w));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_en_i && !bus_we_i) |=> $stable(bus_rdata_o));

    // R5
    irq_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o != '0) |-> (status_w != '0));
endmodule

bind lvl_irq_agg lvl_irq_agg_chk #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_CPUS  (NUM_CPUS),
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .SRC_W     (SRC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_bank_i  (bus_bank_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .status_w    (status_q),
    .masks_w     (mask_all)
);

// File: tb/lvl_irq_agg_tb.sv
module lvl_irq_agg_tb;
    localparam int unsigned NW    = 4;
    localparam int unsigned NC    = 2;
    localparam int unsigned AW    = 8;
    localparam int unsigned SW    = NW * 32;
    localparam int unsigned NVEC  = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] src = '0;
    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [0:0]    bank = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lvl_irq_agg #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .bus_en_i    (en),
        .bus_we_i    (we),
        .bus_bank_i  (bank),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {is_write, bank, offset, data (write value or expected read), expected irq}
    localparam logic [43:0] VECS [NVEC] = '{
        {1'b1, 1'b0, 8'h30, 32'h0000_00FF, 2'b01},  // R4 unmask low byte, R5 bits 4,5 pend
        {1'b0, 1'b0, 8'h10, 32'hFFFF_FF00, 2'b01},  // R4
        {1'b1, 1'b0, 8'h20, 32'h0000_000F, 2'b01},  // R3
        {1'b0, 1'b0, 8'h10, 32'hFFFF_FF0F, 2'b01},  // R3
        {1'b0, 1'b1, 8'h10, 32'hFFFF_FFFF, 2'b01},  // R6 other bank untouched
        {1'b0, 1'b0, 8'h00, 32'h0000_0030, 2'b01},  // R2 status word 0
        {1'b0, 1'b1, 8'h0C, 32'h8000_0000, 2'b01},  // R2 R6 status word 3 seen by bank 1
        {1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF, 2'b01},  // R7 write to mask view
        {1'b0, 1'b0, 8'h10, 32'hFFFF_FF0F, 2'b01},  // R7
        {1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF, 2'b01},  // R7 write to status
        {1'b0, 1'b0, 8'h20, 32'h0000_0000, 2'b01},  // R7 set port reads 0
        {1'b0, 1'b0, 8'h3C, 32'h0000_0000, 2'b01},  // R7 clear port reads 0
        {1'b1, 1'b0, 8'h40, 32'hFFFF_FFFF, 2'b01},  // R8
        {1'b1, 1'b0, 8'h70, 32'h0000_00FF, 2'b01},  // R8
        {1'b0, 1'b0, 8'h40, 32'h0000_0000, 2'b01},  // R8
        {1'b0, 1'b0, 8'h10, 32'hFFFF_FF0F, 2'b01},  // R8 masks unchanged
        {1'b1, 1'b1, 8'h34, 32'hFFFF_0000, 2'b11},  // R4 R6 bank 1 word 1
        {1'b0, 1'b1, 8'h14, 32'h0000_FFFF, 2'b11},  // R2 R6
        {1'b0, 1'b0, 8'h14, 32'hFFFF_FFFF, 2'b11},  // R6
        {1'b0, 1'b0, 8'h08, 32'h0000_0000, 2'b11}   // R2 status word 2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic b, input logic [AW-1:0] a, input logic [31:0] d);
        en = 1'b1; we = w; bank = b; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        en = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 rdata after reset", rdata, 32'h0);
        bus_op(1'b0, 1'b0, 8'h10, '0);
        chk("R1 bank0 mask w0", rdata, 32'hFFFF_FFFF);
        bus_op(1'b0, 1'b1, 8'h1C, '0);
        chk("R1 bank1 mask w3", rdata, 32'hFFFF_FFFF);

        src = {32'h8000_0000, 32'h0000_0000, 32'h0001_0000, 32'h0000_0030};
        repeat (3) @(negedge clk);
        chk("R5 all masked irq", 32'(irq), 32'h0);

        for (int i = 0; i < int'(NVEC); i++) begin
            logic [43:0] v;
            v = VECS[i];
            bus_op(v[43], v[42], v[41:34], v[33:2]);
            if (!v[43]) chk($sformatf("R2 vector %0d rdata", i), rdata, v[33:2]);
            chk($sformatf("R5 vector %0d irq", i), 32'(irq), 32'(v[1:0]));
        end

        // R5: masking the pending bits drops the parent line
        bus_op(1'b1, 1'b0, 8'h20, 32'h0000_0030);
        chk("R5 masked again irq", 32'(irq), 32'h2);

        // R9: two-edge synchronizer delay
        bus_op(1'b1, 1'b0, 8'h30, 32'h0000_0001);
        chk("R9 before src rise", 32'(irq), 32'h2);
        src[0] = 1'b1;
        @(negedge clk);
        chk("R9 one edge after rise", 32'(irq[0]), 32'h0);
        @(negedge clk);
        chk("R9 two edges after rise", 32'(irq[0]), 32'h1);
        bus_op(1'b0, 1'b0, 8'h00, '0);
        chk("R9 status shows source", rdata, 32'h0000_0031);

        // R10: read data holds across writes and idle cycles
        bus_op(1'b1, 1'b1, 8'h20, 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", rdata, 32'h0000_0031);

        src[0] = 1'b0;
        @(negedge clk);
        chk("R9 one edge after fall", 32'(irq[0]), 32'h1);
        @(negedge clk);
        chk("R9 two edges after fall", 32'(irq[0]), 32'h0);

        // R1: reset in the middle of a run
        do_reset();
        chk("R1 irq after mid reset", 32'(irq), 32'h0);
        chk("R1 rdata after mid reset", rdata, 32'h0);
        bus_op(1'b0, 1'b1, 8'h14, '0);
        chk("R1 bank1 mask w1 restored", rdata, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule